// File: doc/BRIEF.md
# Four-Lane Skew-Absorbing Alignment Buffer

This block sits behind four receive lanes that each deliver one decoded character per frame clock. The lanes reach it with different skews. Every lane carries a data byte, a flag that marks a control character, and a lock input. A lane only hunts for the alignment marker while its lock is high. The marker is the control character with code 0x7C. A two-bit select chooses which occurrence of the marker arms the lane. From then on the lane writes each following character into its own eight-entry FIFO. When the last lane has armed, all four FIFOs start draining on the same clock edge. The frame assembler downstream therefore receives the four streams in step.

After release, a monitor counter runs in step with the output stream and wraps at a programmable multiframe length. A marker on any lane's output is expected only on the counter's last count. One marker at a wrong position is tolerated. A second consecutive wrong marker on the same lane flushes every lane and restarts the hunt. A per-lane sticky error flag records any write that a full FIFO could not accept and any read from an empty one. A manual mode bypasses the marker hunt: each lane starts writing as soon as it is locked and begins reading after its own programmed delay.

The top controller has three states. GATHER waits for all lanes to arm. RUN forwards aligned data and monitors marker positions. MANUAL forwards with per-lane fixed delays. Its transitions are ARM_ALL (GATHER to RUN), ENTER_MAN (GATHER to MANUAL), REALIGN, LOST_LANE and MODE_CHG (RUN to GATHER), and LEAVE_MAN (MANUAL to GATHER). Each lane has two states. HUNT counts markers. BUF writes one character every cycle. The lane moves HUNT to BUF on SEL_HIT (the selected marker, or lock in manual mode), and returns to HUNT on DROP (lock low or a flush from the top).

Top module: `lane_aligner`

## Requirements
- R1: Out of reset, tx_valid, aligned, realign and every buf_err bit are 0.
- R2: A marker (rx_ctrl=1 with byte 0x7C) counts toward the occurrence select only on clock edges where that lane's rx_lock is high; markers seen while unlocked are ignored.
- R3: occ_sel = 0, 1, 2, 3 selects the first, second, third or fourth counted marker. The first character each lane forwards is the one that follows its selected marker.
- R4: All lanes begin forwarding on the same edge. tx_valid first rises after the edge that is two edges after the one where the last lane samples its selected marker, and it then stays high while in RUN.
- R5: A skew of up to 7 frame clocks between the earliest and latest lane is absorbed with no buf_err bit set and with correct output.
- R6: A lane whose FIFO holds 8 entries and must accept a write without a read, or must serve a read while empty, sets its buf_err bit. The bit stays set until reset, so a skew of 8 sets it on every lane that armed 8 edges early.
- R7: With manual_en=1, lane i starts writing the edge after lock. Once its output is valid, after edge n it shows the character sampled at edge n-1-d, where d is the lane's 3-bit field manual_dly[3i+2:3i]. tx_valid is high only when all lanes are valid.
- R8: In RUN, a counter is 0 alongside the first forwarded character and wraps after mf_len-1. A marker in the output when the counter is not mf_len-1 is a miss, and a single miss causes no realignment.
- R9: A second consecutive miss on the same lane flushes all lanes and returns to GATHER. realign pulses high for one cycle, and the lanes re-hunt with the same select and come back into alignment.
- R10: aligned is high in RUN and MANUAL, and tx_valid is never high while aligned is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Decoded byte per lane, lane i at [8i+7:8i] |
| rx_ctrl | input | 4 | Control-character flag per lane |
| rx_lock | input | 4 | Per-lane lock |
| occ_sel | input | 2 | Which marker occurrence arms a lane |
| manual_en | input | 1 | Selects fixed-delay mode |
| manual_dly | input | 12 | Per-lane read delay for manual mode, 3 bits each |
| mf_len | input | 8 | Multiframe length in frames (at least 2) |
| tx_data | output | 32 | Aligned bytes, same lane packing as rx_data |
| tx_ctrl | output | 4 | Aligned control flags |
| tx_valid | output | 1 | All lanes hold forwarded data |
| aligned | output | 1 | Controller is in RUN or MANUAL |
| realign | output | 1 | One-cycle pulse after a realignment flush |
| buf_err | output | 4 | Sticky per-lane FIFO overflow/underflow flag |

## Verification
The first read of the release and a write into a completely full FIFO on the earliest lane can fall on the same edge. This happens when the inter-lane skew is exactly 7. The stimulus table provokes this with several lane orderings and occurrence selects. A correct block shows no error flag and the expected first character on every lane. A skew of 8 is the contrast case, in which the write lands one edge before the first read and the error flags are checked. A second coincidence comes from making one lane slip by one frame: a marker miss arrives while the previous verdict for that lane is still held. The bench checks that the first miss leaves realign low, that the second raises it exactly once, and that alignment returns afterwards.

// File: rtl/la_pkg.sv
package la_pkg;
    localparam logic [7:0] ALIGN_CODE = 8'h7C;

    typedef enum logic [0:0] {
        L_HUNT,
        L_BUF
    } lane_state_t;

    typedef enum logic [1:0] {
        T_GATHER,
        T_RUN,
        T_MANUAL
    } top_state_t;
endpackage

// File: rtl/la_fifo.sv
module la_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          underflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign do_rd     = rd_en && !empty;
    assign do_wr     = wr_en && (!full || do_rd);
    assign overflow  = wr_en && !do_wr;
    assign underflow = rd_en && empty;
    assign rd_data   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/la_lane.sv
module la_lane
    import la_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int DLY_W  = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lock,
    input  logic              manual_en,
    input  logic [1:0]        occ_sel,
    input  logic [DLY_W-1:0]  delay,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ctrl,
    input  logic              run_rd,
    input  logic              man_rd,
    output logic              armed,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ctrl,
    output logic              out_vld,
    output logic              err
);
    lane_state_t       state_q, state_d;
    logic [1:0]        occ_q, occ_d;
    logic              is_align, fifo_clr, wr_en, rd_en, ovf, unf;
    logic [DATA_W:0]   rd_word;
    logic [CW-1:0]     fifo_count;

    assign is_align = in_ctrl && (in_data == DATA_W'(ALIGN_CODE));
    assign armed    = (state_q == L_BUF);
    assign wr_en    = armed;
    assign rd_en    = armed && (run_rd || (man_rd && (fifo_count > CW'(delay))));
    assign fifo_clr = !armed || flush || !lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_HUNT;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
        end
    end

    always_comb begin
        state_d = state_q;
        occ_d   = occ_q;
        unique case (state_q)
            L_HUNT: begin
                if (manual_en) begin
                    state_d = L_BUF;
                end else if (is_align) begin
                    if (occ_q == occ_sel) state_d = L_BUF;
                    else                  occ_d   = occ_q + 2'd1;
                end
            end
            L_BUF: ;
        endcase
        if (!lock || flush) begin
            state_d = L_HUNT;
            occ_d   = '0;
        end
    end

    la_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clr),
        .wr_en     (wr_en),
        .wr_data   ({in_ctrl, in_data}),
        .rd_en     (rd_en),
        .rd_data   (rd_word),
        .count     (fifo_count),
        .overflow  (ovf),
        .underflow (unf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            out_ctrl <= 1'b0;
            out_vld  <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= err | (!fifo_clr && (ovf || unf));
            if (fifo_clr) begin
                out_vld <= 1'b0;
            end else begin
                out_vld <= rd_en && (fifo_count != '0);
                if (rd_en && (fifo_count != '0)) begin
                    out_data <= rd_word[DATA_W-1:0];
                    out_ctrl <= rd_word[DATA_W];
                end
            end
        end
    end

    AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> (state_q == L_HUNT && !out_vld)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && lock && !flush && fifo_count == CW'(DEPTH) && !rd_en) |=> err); // R6
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (man_rd && !run_rd && armed && lock && !flush && fifo_count <= CW'(delay)) |=> !out_vld); // R7
endmodule

// File: rtl/la_monitor.sv
module la_monitor #(
    parameter int NUM_LANES = 4,
    parameter int MF_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic [MF_W-1:0]      mf_len,
    input  logic [NUM_LANES-1:0] lane_a,
    output logic                 realign_req
);
    logic [MF_W-1:0]      cnt_q, last;
    logic [NUM_LANES-1:0] miss_now, miss_q;

    assign last        = mf_len - MF_W'(1);
    assign miss_now    = (active && (cnt_q != last)) ? lane_a : '0;
    assign realign_req = |(miss_q & miss_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else if (!active) begin
            cnt_q  <= last;
            miss_q <= '0;
        end else begin
            cnt_q  <= (cnt_q == last) ? '0 : cnt_q + MF_W'(1);
            miss_q <= (miss_q & ~lane_a) | miss_now;
        end
    end

    AST_SINGLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && miss_q == '0) |-> !realign_req); // R8
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_q == last && $stable(mf_len)) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import la_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int MF_W       = 8,
    parameter int DLY_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*DATA_W-1:0] rx_data,
    input  logic [NUM_LANES-1:0]        rx_ctrl,
    input  logic [NUM_LANES-1:0]        rx_lock,
    input  logic [1:0]                  occ_sel,
    input  logic                        manual_en,
    input  logic [NUM_LANES*DLY_W-1:0]  manual_dly,
    input  logic [MF_W-1:0]             mf_len,
    output logic [NUM_LANES*DATA_W-1:0] tx_data,
    output logic [NUM_LANES-1:0]        tx_ctrl,
    output logic                        tx_valid,
    output logic                        aligned,
    output logic                        realign,
    output logic [NUM_LANES-1:0]        buf_err
);
    top_state_t           state_q, state_d;
    logic                 flush, realign_req, run_rd, man_rd;
    logic [NUM_LANES-1:0] armed, lane_vld, lane_a;

    assign run_rd   = (state_q == T_RUN);
    assign man_rd   = (state_q == T_MANUAL);
    assign tx_valid = &lane_vld;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        la_lane #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .DLY_W(DLY_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .lock      (rx_lock[i]),
            .manual_en (manual_en),
            .occ_sel   (occ_sel),
            .delay     (manual_dly[i*DLY_W +: DLY_W]),
            .in_data   (rx_data[i*DATA_W +: DATA_W]),
            .in_ctrl   (rx_ctrl[i]),
            .run_rd    (run_rd),
            .man_rd    (man_rd),
            .armed     (armed[i]),
            .out_data  (tx_data[i*DATA_W +: DATA_W]),
            .out_ctrl  (tx_ctrl[i]),
            .out_vld   (lane_vld[i]),
            .err       (buf_err[i])
        );
        assign lane_a[i] = lane_vld[i] && tx_ctrl[i]
                           && (tx_data[i*DATA_W +: DATA_W] == DATA_W'(ALIGN_CODE));
    end

    la_monitor #(.NUM_LANES(NUM_LANES), .MF_W(MF_W)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (run_rd),
        .mf_len      (mf_len),
        .lane_a      (lane_a),
        .realign_req (realign_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_GATHER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        flush   = 1'b0;
        unique case (state_q)
            T_GATHER: begin
                if (manual_en)   state_d = T_MANUAL;
                else if (&armed) state_d = T_RUN;
            end
            T_RUN: begin
                if (manual_en || realign_req || !(&armed)) begin
                    state_d = T_GATHER;
                    flush   = 1'b1;
                end
            end
            T_MANUAL: begin
                if (!manual_en) begin
                    state_d = T_GATHER;
                    flush   = 1'b1;
                end
            end
            default: state_d = T_GATHER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) realign <= 1'b0;
        else        realign <= (state_q == T_RUN) && realign_req;
    end

    assign aligned = (state_q == T_RUN) || (state_q == T_MANUAL);

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && &armed) |-> (lane_vld == '0 || lane_vld == '1)); // R4
    AST_REALIGN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && realign_req) |=> (state_q == T_GATHER && !tx_valid && realign)); // R9
    AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> aligned); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_err) |=> ((buf_err & $past(buf_err)) == $past(buf_err))); // R6
endmodule

// File: tb/tb_lane_aligner.sv
module tb_lane_aligner;
    localparam int PRE = 4;
    localparam int MF  = 16;
    localparam int NR  = 6;
    // {sel[31:30], lock_start[29:22], exp_idx[21:20], skew3..skew0[19:4], err_mask[3:0]}
    localparam logic [31:0] VEC [NR] = '{
        {2'd0, 8'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'b0000},
        {2'd1, 8'd0, 2'd1, 4'd2, 4'd7, 4'd3, 4'd0, 4'b0000},
        {2'd3, 8'd0, 2'd3, 4'd7, 4'd1, 4'd0, 4'd5, 4'b0000},
        {2'd2, 8'd0, 2'd2, 4'd7, 4'd7, 4'd7, 4'd7, 4'b0000},
        {2'd0, 8'd6, 2'd1, 4'd1, 4'd0, 4'd1, 4'd0, 4'b0000},
        {2'd0, 8'd0, 2'd0, 4'd0, 4'd0, 4'd8, 4'd0, 4'b1101}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctrl = '0, rx_lock = '0;
    logic [1:0]  occ_sel = '0;
    logic        manual_en = 1'b0;
    logic [11:0] manual_dly = '0;
    logic [7:0]  mf_len = 8'(MF);
    logic [31:0] tx_data;
    logic [3:0]  tx_ctrl, buf_err;
    logic        tx_valid, aligned, realign;

    int n_chk = 0, n_fail = 0, n_realign = 0;
    int skew [4];
    int lock_start = 0;

    always #4 clk = ~clk;

    lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_lock(rx_lock),
        .occ_sel(occ_sel), .manual_en(manual_en), .manual_dly(manual_dly), .mf_len(mf_len),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_valid(tx_valid), .aligned(aligned),
        .realign(realign), .buf_err(buf_err)
    );

    function automatic logic [8:0] sym(input int lane, input int t);
        if (t < 0) return {1'b1, 8'hBC};
        if (t % MF == 0) return {1'b1, 8'h7C};
        return {1'b0, 8'(t + 16 * lane)};
    endfunction

    function automatic logic [8:0] lane_out(input int i);
        return {tx_ctrl[i], tx_data[i*8 +: 8]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int n);
        for (int i = 0; i < 4; i++) begin
            logic [8:0] s;
            s = sym(i, n - skew[i] - PRE);
            rx_data[i*8 +: 8] = s[7:0];
            rx_ctrl[i]        = s[8];
            rx_lock[i]        = (n >= lock_start);
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        rx_lock = '0;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        n_realign = 0;
    endtask

    task automatic check_consistent(input string req);
        logic [8:0] s0;
        s0 = lane_out(0);
        for (int i = 1; i < 4; i++) begin
            logic [8:0] e;
            e = s0[8] ? s0 : {1'b0, 8'(s0[7:0] + 8'(16 * i))};
            chk(lane_out(i) == e, req, 32'(lane_out(i)), 32'(e));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(!tx_valid && !aligned && !realign && buf_err == '0, "R1",
            {tx_valid, aligned, realign, buf_err}, 32'd0);

        // Table-driven auto-mode scenarios
        for (int r = 0; r < NR; r++) begin
            int sel, expi, dmax, na, last_m;
            logic [3:0] mask;
            string dreq;
            sel        = int'(VEC[r][31:30]);
            lock_start = int'(VEC[r][29:22]);
            expi       = int'(VEC[r][21:20]);
            mask       = VEC[r][3:0];
            dmax       = 0;
            for (int i = 0; i < 4; i++) begin
                skew[i] = int'(VEC[r][4 + 4*i +: 4]);
                if (skew[i] > dmax) dmax = skew[i];
            end
            dreq      = (lock_start > 0) ? "R2" : ((dmax == 7) ? "R5" : "R3");
            occ_sel   = 2'(sel);
            manual_en = 1'b0;
            do_reset();
            na     = PRE + expi * MF + dmax;
            last_m = na + 42;
            for (int n = 0; n <= last_m + 1; n++) begin
                @(negedge clk);
                if (n > 0) begin
                    int m;
                    m = n - 1;
                    if (realign) n_realign++;
                    if (mask == '0) begin
                        if (m == na + 1) chk(!tx_valid, "R4", 32'(tx_valid), 32'd0);
                        if (m >= na + 2) begin
                            chk(tx_valid, "R4", 32'(tx_valid), 32'd1);
                            for (int i = 0; i < 4; i++) begin
                                logic [8:0] e;
                                e = sym(i, expi * MF + 1 + (m - na - 2));
                                chk(lane_out(i) == e, dreq, 32'(lane_out(i)), 32'(e));
                            end
                        end
                    end
                end
                drive(n);
            end
            if (mask == '0) begin
                chk(buf_err == '0, "R5", 32'(buf_err), 32'd0);
                chk(n_realign == 0, "R8", 32'(n_realign), 32'd0);
                chk(aligned, "R10", 32'(aligned), 32'd1);
            end else begin
                chk(buf_err == mask, "R6", 32'(buf_err), 32'(mask));
            end
        end

        // R7: manual mode, per-lane delays 0,2,5,7
        for (int i = 0; i < 4; i++) skew[i] = 0;
        lock_start = 0;
        occ_sel    = 2'd0;
        manual_dly = {3'd7, 3'd5, 3'd2, 3'd0};
        manual_en  = 1'b1;
        do_reset();
        for (int n = 0; n <= 41; n++) begin
            @(negedge clk);
            if (n > 0) begin
                int m;
                m = n - 1;
                if (m == 8) chk(!tx_valid, "R7", 32'(tx_valid), 32'd0);
                if (m >= 9) begin
                    chk(tx_valid && aligned, "R7", {tx_valid, aligned}, 32'd3);
                    for (int i = 0; i < 4; i++) begin
                        int d;
                        logic [8:0] e;
                        d = int'(manual_dly[3*i +: 3]);
                        e = sym(i, m - 1 - d - PRE);
                        chk(lane_out(i) == e, "R7", 32'(lane_out(i)), 32'(e));
                    end
                end
            end
            drive(n);
        end
        manual_en = 1'b0;

        // R8/R9: lane 1 slips one frame, two consecutive misses trigger realignment
        for (int i = 0; i < 4; i++) skew[i] = 0;
        occ_sel = 2'd0;
        do_reset();
        for (int n = 0; n <= 141; n++) begin
            @(negedge clk);
            if (n > 0) begin
                int m;
                m = n - 1;
                if (realign) n_realign++;
                if (m == 80) chk(n_realign == 0, "R8", 32'(n_realign), 32'd0);
                if (m == 100) chk(n_realign == 1, "R9", 32'(n_realign), 32'd1);
                if (m >= 110) begin
                    chk(tx_valid && aligned, "R9", {tx_valid, aligned}, 32'd3);
                    check_consistent("R9");
                end
            end
            if (n == 60) skew[1] = 1;
            drive(n);
        end
        chk(n_realign == 1, "R9", 32'(n_realign), 32'd1);
        chk(buf_err == '0, "R6", 32'(buf_err), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule